// File: doc/BRIEF.md
# Doorbell Mailbox Interrupt Unit

This block is a memory-mapped doorbell between two processors. It has three physical channels: channel 0 is the low-priority non-secure channel, channel 1 is the high-priority non-secure channel and channel 2 is the secure channel. Each channel owns two banks. The receive bank raises an interrupt toward the local processor. The transmit bank presents its event word and an interrupt toward the remote processor. Every bank holds a 32-bit event word. Software changes single bits of that word through a set register and a clear register, so each bit can serve as a separate subchannel. Any bit that is set keeps the bank's interrupt asserted.

A sender rings a doorbell by writing a mask to a set register. The receiver acknowledges by clearing the bits it has handled. The sender polls the status word until the bits it raised read back as zero. The remote processor clears transmit-bank bits through a dedicated clear port, which behaves like the local clear register. A simple single-cycle register bus reaches all six banks. Read data is combinational from the address, and a write takes effect on the clock edge at which the write strobe is sampled.

Top module: `doorbell_mbx`

## Requirements
- R1: After a synchronous active-low reset, every event word in all six banks is zero, and every interrupt and transmit output is low.
- R2: A bus write to a bank's set register (bank base + 0x08) ORs the written value into that bank's word. All other bits of the word keep their values.
- R3: A bus write to a bank's clear register (bank base + 0x10) clears exactly the bits that are 1 in the written value. All other bits of the word keep their values.
- R4: `rx_irq[c]` is high in the cycle after a write exactly when the receive word of channel c is nonzero, and it drops once every bit of that word has been cleared.
- R5: The receive bank bases are 0x000 for channel 0, 0x020 for channel 1 and 0x200 for channel 2. Each transmit bank sits 0x100 above its channel's receive bank. The status word of a bank reads at offset 0x00.
- R6: `tx_word` bits [32c+31:32c] carry the transmit word of channel c. `tx_irq[c]` is high exactly when that word is nonzero.
- R7: In a cycle where `remote_clr` bits [32c+31:32c] hold a mask, the transmit word of channel c has the 1 bits of that mask cleared. `remote_clr` has no effect on any receive word.
- R8: When a set and a clear of the same bit in a transmit word arrive in the same cycle, from the bus and from `remote_clr`, the bit ends up set.
- R9: Reads of set and clear registers return zero. Reads of unmapped addresses return zero. Writes to status registers or to unmapped addresses change no event word.
- R10: A write addressed to one bank leaves the words of all other banks unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| remote_clr | input | 96 | Remote clear masks, 32 bits per channel, for the transmit words |
| rx_irq | output | 3 | Local receive interrupt per channel |
| tx_irq | output | 3 | Remote-side interrupt per channel |
| tx_word | output | 96 | Transmit event words, 32 bits per channel |

## Verification
The set and clear paths are driven with sparse masks, single high bits, masks that mix halves and all-ones masks. These patterns show whether a write merges into the word or overwrites it, and whether a clear touches bits outside its mask. Writes go to all three channels in turn and are followed by reads of every other bank, which separates a correct address map from aliasing between channels and between directions. A same-cycle bus set and remote clear on overlapping bits shows which side wins. Writes to status registers and unmapped addresses, together with reads of the write-only registers, show that decode misses have no side effects.

// File: rtl/mbx_pkg.sv
// Package: shared constants and the address map of the doorbell mailbox.
// Assumes byte addressing with 32-bit registers on 8-byte spacing in a bank.
package mbx_pkg;
    localparam int unsigned DEF_NUM_CH = 3;
    localparam int unsigned DEF_WORD_W = 32;
    localparam int unsigned DEF_ADDR_W = 12;

    // Register offsets inside one bank; a bank spans 2**OFS_W bytes.
    localparam int unsigned OFS_W      = 5;
    localparam int unsigned OFS_STATUS = 'h00;
    localparam int unsigned OFS_SET    = 'h08;
    localparam int unsigned OFS_CLR    = 'h10;

    // Distance from a channel's receive bank to its transmit bank.
    localparam int unsigned TX_SHIFT   = 'h100;

    // Receive-bank base for a channel: the two non-secure channels sit low,
    // the remaining channels start at 0x200.
    function automatic int unsigned rx_base(input int unsigned ch);
        if (ch < 2) return ch * 'h20;
        return 'h200 + (ch - 2) * 'h20;
    endfunction

    // Base of bank b, where b = 2*channel + direction (0 receive, 1 transmit).
    function automatic int unsigned bank_base(input int unsigned b);
        return rx_base(b / 2) + (b % 2) * TX_SHIFT;
    endfunction
endpackage

// File: rtl/mbx_bank_decode.sv
// Module: address decoder for all banks.
// Produces one-hot-or-zero strobes for status reads, set writes and clear
// writes. Assumes bank bases are aligned to 2**OFS_W bytes and never overlap.
module mbx_bank_decode
    import mbx_pkg::*;
#(
    parameter int unsigned ADDR_W   = DEF_ADDR_W,
    parameter int unsigned NUM_BANK = 2 * DEF_NUM_CH
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr,
    output logic [NUM_BANK-1:0] stat_hit,
    output logic [NUM_BANK-1:0] set_hit,
    output logic [NUM_BANK-1:0] clr_hit
);
    localparam logic [OFS_W-1:0] SEL_STAT = OFS_W'(OFS_STATUS);
    localparam logic [OFS_W-1:0] SEL_SET  = OFS_W'(OFS_SET);
    localparam logic [OFS_W-1:0] SEL_CLR  = OFS_W'(OFS_CLR);

    logic [OFS_W-1:0] offset;
    assign offset = addr[OFS_W-1:0];

    for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
        localparam logic [ADDR_W-1:0] BASE = ADDR_W'(bank_base(b));
        logic in_bank;
        // Bank match on the address bits above the in-bank offset.
        assign in_bank     = (addr[ADDR_W-1:OFS_W] == BASE[ADDR_W-1:OFS_W]);
        assign stat_hit[b] = in_bank && (offset == SEL_STAT);
        assign set_hit[b]  = wr && in_bank && (offset == SEL_SET);
        assign clr_hit[b]  = wr && in_bank && (offset == SEL_CLR);
    end
endmodule

// File: rtl/mbx_event_word.sv
// Module: one event word with per-bit set and clear and an OR-reduced flag.
// Set wins over clear for the same bit in the same cycle.
module mbx_event_word #(
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] set_mask,
    input  logic [WORD_W-1:0] clr_mask,
    output logic [WORD_W-1:0] word,
    output logic              any
);
    // Update the word: drop cleared bits, then add set bits.
    always_ff @(posedge clk) begin
        if (!rst_n) word <= '0;
        else        word <= (word & ~clr_mask) | set_mask;
    end

    // Flag any pending bit.
    always_comb any = |word;
endmodule

// File: rtl/mbx_read_mux.sv
// Module: read-data selection.
// Returns the word of the bank whose status register is addressed, and zero
// otherwise. Assumes at most one bank hit per address.
module mbx_read_mux #(
    parameter int unsigned WORD_W   = 32,
    parameter int unsigned NUM_BANK = 6
) (
    input  logic [NUM_BANK-1:0]        stat_hit,
    input  logic [NUM_BANK*WORD_W-1:0] words,
    output logic [WORD_W-1:0]          rdata
);
    // OR together the gated bank words.
    always_comb begin
        rdata = '0;
        for (int b = 0; b < NUM_BANK; b++)
            if (stat_hit[b]) rdata = rdata | words[b*WORD_W +: WORD_W];
    end
endmodule

// File: rtl/doorbell_mbx.sv
// Module: doorbell mailbox top.
// NUM_CH channels, each with a receive bank and a transmit bank on a simple
// register bus. Bank b = 2*channel + direction. The remote side clears
// transmit bits through remote_clr. Assumes one bus access per cycle.
module doorbell_mbx
    import mbx_pkg::*;
#(
    parameter int unsigned NUM_CH = DEF_NUM_CH,
    parameter int unsigned WORD_W = DEF_WORD_W,
    parameter int unsigned ADDR_W = DEF_ADDR_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [WORD_W-1:0]        bus_wdata,
    input  logic                     bus_wr,
    output logic [WORD_W-1:0]        bus_rdata,
    input  logic [NUM_CH*WORD_W-1:0] remote_clr,
    output logic [NUM_CH-1:0]        rx_irq,
    output logic [NUM_CH-1:0]        tx_irq,
    output logic [NUM_CH*WORD_W-1:0] tx_word
);
    localparam int unsigned NUM_BANK = 2 * NUM_CH;

    logic [NUM_BANK-1:0]        stat_hit, set_hit, clr_hit;
    logic [NUM_BANK-1:0]        bank_any;
    logic [NUM_BANK*WORD_W-1:0] bank_words;

    mbx_bank_decode #(.ADDR_W(ADDR_W), .NUM_BANK(NUM_BANK)) u_dec (
        .addr     (bus_addr),
        .wr       (bus_wr),
        .stat_hit (stat_hit),
        .set_hit  (set_hit),
        .clr_hit  (clr_hit)
    );

    for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
        logic [WORD_W-1:0] set_m, clr_m, far_clr;

        // Only transmit banks (odd index) see the remote clear port.
        if (b % 2 == 1) begin : g_tx
            assign far_clr = remote_clr[(b/2)*WORD_W +: WORD_W];
        end else begin : g_rx
            assign far_clr = '0;
        end

        assign set_m = set_hit[b] ? bus_wdata : '0;
        assign clr_m = (clr_hit[b] ? bus_wdata : '0) | far_clr;

        mbx_event_word #(.WORD_W(WORD_W)) u_word (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_mask (set_m),
            .clr_mask (clr_m),
            .word     (bank_words[b*WORD_W +: WORD_W]),
            .any      (bank_any[b])
        );
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_out
        assign rx_irq[c] = bank_any[2*c];
        assign tx_irq[c] = bank_any[2*c+1];
        assign tx_word[c*WORD_W +: WORD_W] = bank_words[(2*c+1)*WORD_W +: WORD_W];
    end

    mbx_read_mux #(.WORD_W(WORD_W), .NUM_BANK(NUM_BANK)) u_rd (
        .stat_hit (stat_hit),
        .words    (bank_words),
        .rdata    (bus_rdata)
    );
endmodule

// File: rtl/doorbell_mbx_chk.sv
// Module: property checker for doorbell_mbx, attached by bind.
// Observes only top-level ports. Assumes the default address map of mbx_pkg.
module doorbell_mbx_chk
    import mbx_pkg::*;
#(
    parameter int unsigned NUM_CH = DEF_NUM_CH,
    parameter int unsigned WORD_W = DEF_WORD_W,
    parameter int unsigned ADDR_W = DEF_ADDR_W
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [ADDR_W-1:0]        bus_addr,
    input logic [WORD_W-1:0]        bus_wdata,
    input logic                     bus_wr,
    input logic [NUM_CH*WORD_W-1:0] remote_clr,
    input logic [NUM_CH-1:0]        rx_irq,
    input logic [NUM_CH-1:0]        tx_irq,
    input logic [NUM_CH*WORD_W-1:0] tx_word
);
    // True when the address is a set or clear register of some bank.
    function automatic logic is_write_reg(input logic [ADDR_W-1:0] a);
        for (int unsigned b = 0; b < 2 * NUM_CH; b++) begin
            if (a == ADDR_W'(bank_base(b) + OFS_SET)) return 1'b1;
            if (a == ADDR_W'(bank_base(b) + OFS_CLR)) return 1'b1;
        end
        return 1'b0;
    endfunction

    logic in_rst_q;

    // R1: the cycle after a reset edge, all outputs are quiet.
    always_ff @(posedge clk) begin
        in_rst_q <= !rst_n;
        if (in_rst_q === 1'b1)
            a_r1_reset_zero: assert (tx_word == '0 && rx_irq == '0 && tx_irq == '0);
    end

    // R9: writes that hit no set/clear register change nothing.
    a_r9_miss_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !is_write_reg(bus_addr) && remote_clr == '0)
        |=> ($stable(tx_word) && $stable(rx_irq) && $stable(tx_irq)));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam logic [ADDR_W-1:0] RX_SET = ADDR_W'(rx_base(c) + OFS_SET);
        localparam logic [ADDR_W-1:0] RX_CLR = ADDR_W'(rx_base(c) + OFS_CLR);
        localparam logic [ADDR_W-1:0] TX_SET = ADDR_W'(rx_base(c) + TX_SHIFT + OFS_SET);

        // R2 and R8: set bits always land, even against a remote clear.
        a_r2_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == TX_SET)
            |=> ((tx_word[c*WORD_W +: WORD_W] & $past(bus_wdata)) == $past(bus_wdata)));

        // R4: a receive interrupt rises only after a set write to its bank.
        a_r4_rx_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rx_irq[c]) |-> $past(bus_wr && bus_addr == RX_SET));

        // R3: an all-ones clear empties the receive word.
        a_r3_full_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == RX_CLR && bus_wdata == '1) |=> !rx_irq[c]);

        // R7: a full remote clear with no competing set empties the transmit word.
        a_r7_remote_wipe: assert property (@(posedge clk) disable iff (!rst_n)
            (remote_clr[c*WORD_W +: WORD_W] == '1 && !(bus_wr && bus_addr == TX_SET))
            |=> (tx_word[c*WORD_W +: WORD_W] == '0 && !tx_irq[c]));
    end
endmodule

bind doorbell_mbx doorbell_mbx_chk #(
    .NUM_CH (NUM_CH),
    .WORD_W (WORD_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_wr     (bus_wr),
    .remote_clr (remote_clr),
    .rx_irq     (rx_irq),
    .tx_irq     (tx_irq),
    .tx_word    (tx_word)
);

// File: tb/doorbell_mbx_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: stimulus tasks update a bench-side model and queue
// expected values; a monitor at the falling edge compares them.
module doorbell_mbx_tb;
    localparam int NCH = 3;
    localparam int W   = 32;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [11:0]    bus_addr = '0;
    logic [W-1:0]   bus_wdata = '0;
    logic           bus_wr = 1'b0;
    logic [W-1:0]   bus_rdata;
    logic [NCH*W-1:0] remote_clr = '0;
    logic [NCH-1:0] rx_irq, tx_irq;
    logic [NCH*W-1:0] tx_word;

    int n_total = 0;
    int n_bad   = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    doorbell_mbx u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rdata(bus_rdata), .remote_clr(remote_clr),
        .rx_irq(rx_irq), .tx_irq(tx_irq), .tx_word(tx_word)
    );

    // Expected item: kind 0 read data, 1 rx_irq, 2 tx_irq, 3 tx_word of channel idx.
    typedef struct {
        int          kind;
        int          idx;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    logic [31:0] model [2*NCH];   // bank = 2*channel + direction

    // Bank base from the map in R5.
    function automatic int base_of(input int b);
        int ch = b / 2;
        int rx = (ch < 2) ? ch * 'h20 : 'h200 + (ch - 2) * 'h20;
        return rx + (b % 2) * 'h100;
    endfunction

    function automatic logic [31:0] model_read(input logic [11:0] a);
        for (int b = 0; b < 2*NCH; b++)
            if (int'(a) == base_of(b)) return model[b];
        return 32'h0;
    endfunction

    // Drive one cycle of inputs and advance the model.
    task automatic step(input logic w, input logic [11:0] a, input logic [31:0] d,
                        input logic [NCH*W-1:0] rc);
        @(posedge clk); #1;
        bus_wr = w; bus_addr = a; bus_wdata = d; remote_clr = rc;
        for (int b = 0; b < 2*NCH; b++) begin
            logic [31:0] sm, cm;
            sm = (w && int'(a) == base_of(b) + 'h08) ? d : 32'h0;
            cm = (w && int'(a) == base_of(b) + 'h10) ? d : 32'h0;
            if (b % 2 == 1) cm = cm | rc[(b/2)*W +: W];
            model[b] = (model[b] & ~cm) | sm;
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        step(1'b1, a, d, '0);
    endtask

    task automatic exp_rd(input logic [11:0] a, input string tag);
        item_t it;
        step(1'b0, a, 32'h0, '0);
        it.kind = 0; it.idx = int'(a); it.exp = model_read(a); it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic exp_outs(input string tag);
        item_t it;
        step(1'b0, 12'h0, 32'h0, '0);
        it.tag = tag; it.idx = 0;
        it.kind = 1; it.exp = '0;
        for (int c = 0; c < NCH; c++) it.exp[c] = |model[2*c];
        sb.push_back(it);
        it.kind = 2; it.exp = '0;
        for (int c = 0; c < NCH; c++) it.exp[c] = |model[2*c+1];
        sb.push_back(it);
        for (int c = 0; c < NCH; c++) begin
            it.kind = 3; it.idx = c; it.exp = model[2*c+1];
            sb.push_back(it);
        end
    endtask

    // Monitor: compare every queued expectation in the middle of the cycle.
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            case (it.kind)
                0:       act = bus_rdata;
                1:       act = 32'(rx_irq);
                2:       act = 32'(tx_irq);
                default: act = tx_word[it.idx*W +: W];
            endcase
            n_total++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s kind=%0d idx=%0h actual=%h expected=%h",
                         it.tag, it.kind, it.idx, act, it.exp);
            end
        end
    end

    initial begin
        for (int b = 0; b < 2*NCH; b++) model[b] = '0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state of every bank and output.
        for (int b = 0; b < 2*NCH; b++) exp_rd(12'(base_of(b)), "R1 reset status");
        exp_outs("R1 reset outputs");

        // R2, R4: set merges bits and raises the channel 0 interrupt.
        wr(12'h008, 32'h0000_0005);
        exp_rd(12'h000, "R2 first set");
        exp_outs("R4 rx irq ch0");
        wr(12'h008, 32'h0000_0100);
        exp_rd(12'h000, "R2 second set keeps bits");

        // R3: clear only the masked bit.
        wr(12'h010, 32'h0000_0004);
        exp_rd(12'h000, "R3 partial clear");
        exp_outs("R3 irq stays with bits left");

        // R5, R10: other channels at their own bases.
        wr(12'h208, 32'h8000_0000);
        exp_outs("R5 secure channel irq index 2");
        wr(12'h028, 32'hA5A5_0000);
        exp_rd(12'h020, "R5 high-priority bank");
        exp_rd(12'h200, "R10 secure bank untouched");
        exp_rd(12'h000, "R10 low bank untouched");

        // R4: full clear drops the interrupt.
        wr(12'h010, 32'hFFFF_FFFF);
        exp_outs("R4 irq falls after clear");

        // R6, R10: transmit bank of channel 1.
        wr(12'h128, 32'h0000_0030);
        exp_outs("R6 tx word and irq");
        exp_rd(12'h120, "R6 tx status read");
        exp_rd(12'h020, "R10 rx bank of same channel");

        // R7: remote clear of one bit, receive side unaffected.
        step(1'b0, 12'h0, 32'h0, {32'h0, 32'h0000_0010, 32'h0});
        exp_outs("R7 remote clear");
        step(1'b0, 12'h0, 32'h0, {32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF});
        exp_rd(12'h020, "R7 remote clear leaves rx");
        exp_rd(12'h200, "R7 remote clear leaves secure rx");

        // R8: set and remote clear on the same bit in one cycle.
        step(1'b1, 12'h128, 32'h0000_0001, {32'h0, 32'h0000_0021, 32'h0});
        exp_outs("R8 set wins");
        exp_rd(12'h120, "R8 status after collision");

        // R3: receiver clears, sender sees zero.
        wr(12'h130, 32'h0000_0001);
        exp_rd(12'h120, "R3 tx status zero after clear");
        exp_outs("R3 tx irq low");

        // R9: write-only registers and unmapped space read zero.
        exp_rd(12'h028, "R9 set reg reads zero");
        exp_rd(12'h030, "R9 clr reg reads zero");
        exp_rd(12'h040, "R9 unmapped reads zero");
        exp_rd(12'h004, "R9 gap reads zero");

        // R9: writes to status and unmapped addresses are ignored.
        wr(12'h020, 32'h0000_0000);
        wr(12'h040, 32'hFFFF_FFFF);
        wr(12'h300, 32'hFFFF_FFFF);
        exp_rd(12'h020, "R9 status write ignored");
        exp_rd(12'h300, "R9 tx status write ignored");
        exp_outs("R9 outputs unchanged");

        // R6: transmit banks of channels 0 and 2.
        wr(12'h108, 32'h1234_0001);
        wr(12'h308, 32'h0000_8000);
        exp_outs("R6 tx ch0 and ch2");

        @(posedge clk); #1;
        bus_wr = 1'b0; remote_clr = '0;
        @(negedge clk); #1;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_total++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    end
endmodule